// File: doc/BRIEF.md
# Transmit Bit-Rate Clock Scaler

This block turns a base clock into a one-cycle bit-enable strobe that paces a serial transmitter. An 8-bit down counter reloads from a selected divisor whenever it reaches zero and fires one strobe per reload. The strobes are therefore spaced divisor + 1 base clocks apart.

Two divisors are available. A compile-time default gives 10 Mbit/s. It is derived from the base clock frequency, which is the system clock frequency in generic mode and a separate transmit clock frequency in fast mode. The default applies while the link is still being brought up. Once the link-running flag is high, the runtime divisor input applies instead.

A switch between the two divisors, or any change of the runtime divisor, acts on the very next clock edge. If the new divisor is below the value still left in the counter, the counter reloads at once instead of running down from the old value. Data-strobe encoding and clock-domain crossing belong to neighbouring blocks.

Top module: `txrate_scaler`

## Requirements
- R1: While `rstN` is low, `bitEn` is low and the counter is cleared. The first strobe appears on the first rising clock edge after `rstN` goes high.
- R2: The default divisor is (base frequency / 10 MHz) − 1, truncated to 8 bits. The base frequency is `SYS_FREQ_HZ` when `USE_FAST_CLK` is 0 and `TX_FREQ_HZ` when it is 1.
- R3: While `linkRun` is low, strobes are spaced default divisor + 1 cycles apart and `rateDiv` has no effect on them.
- R4: While `linkRun` is high, strobes are spaced `rateDiv` + 1 cycles apart, with `rateDiv` read as an unsigned 8-bit value.
- R5: A selected divisor of 0 gives a strobe on every cycle, and a divisor of 255 gives a spacing of 256 cycles.
- R6: With a non-zero divisor, each strobe is exactly one cycle wide, and there is exactly one strobe per counter reload.
- R7: When the selected divisor drops below the current count, the counter reloads and a strobe appears on the next clock edge.
- R8: A change of `linkRun` switches between the default and runtime divisors on the next edge, under the same reload rule as R7.
- R9: Between reloads, the counter decreases by exactly one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock: system clock in generic mode, transmit clock in fast mode |
| rstN | input | 1 | Synchronous active-low reset |
| linkRun | input | 1 | High once the link is running; selects the runtime divisor |
| rateDiv | input | 8 | Runtime divisor minus one |
| bitEn | output | 1 | One-cycle transmit bit enable strobe |

## Verification
The bench builds two copies of the block. One is in generic mode with a 200 MHz system clock, which gives a default divisor of 19. The other is in fast mode with a 50 MHz transmit clock, which gives a default divisor of 4. Together they reach both branches of the base-frequency selection. The 200 MHz build also leaves room to compare the default spacing against runtime divisors both above and below it. That covers the shrinking reload in both the link-up direction and the link-drop direction, as well as the extremes 0 and 255.

// File: rtl/txrate_pkg.sv
package txrate_pkg;

  typedef struct packed {
    logic reload;
    logic step;
  } scaleCtl_t;

  function automatic int calcDefault(input int baseHz, input int rateHz);
    return baseHz / rateHz - 1;
  endfunction

endpackage

// File: rtl/txrate_ctrl.sv
module txrate_ctrl
  import txrate_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             linkRun,
  input  logic [CNT_W-1:0] rateDiv,
  input  logic [CNT_W-1:0] defDiv,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] selDiv,
  output scaleCtl_t        ctl
);

  logic atZero;
  logic overshoot;

  always_comb begin
    selDiv    = linkRun ? rateDiv : defDiv;
    atZero    = (cnt == '0);
    overshoot = (cnt > selDiv);
    ctl.reload = atZero || overshoot;
    ctl.step   = !ctl.reload;
  end

endmodule

// File: rtl/txrate_dp.sv
module txrate_dp
  import txrate_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  scaleCtl_t        ctl,
  input  logic [CNT_W-1:0] selDiv,
  output logic [CNT_W-1:0] cnt,
  output logic             bitEn
);

  logic [CNT_W-1:0] cntQ;
  logic             bitEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      bitEnQ <= 1'b0;
    end else begin
      bitEnQ <= ctl.reload;
      if (ctl.reload) begin
        cntQ <= selDiv;
      end else if (ctl.step) begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  assign cnt   = cntQ;
  assign bitEn = bitEnQ;

endmodule

// File: rtl/txrate_scaler.sv
module txrate_scaler
  import txrate_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int SYS_FREQ_HZ  = 200_000_000,
  parameter int TX_FREQ_HZ   = 50_000_000,
  parameter int BIT_RATE_HZ  = 10_000_000,
  parameter bit USE_FAST_CLK = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       linkRun,
  input  logic [7:0] rateDiv,
  output logic       bitEn
);

  localparam int SYS_DEF = calcDefault(SYS_FREQ_HZ, BIT_RATE_HZ);
  localparam int TX_DEF  = calcDefault(TX_FREQ_HZ, BIT_RATE_HZ);

  logic [CNT_W-1:0] defDiv;
  logic [CNT_W-1:0] selDiv;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] rateDivW;
  scaleCtl_t        ctl;

  generate
    if (USE_FAST_CLK) begin : g_fastBase
      assign defDiv = TX_DEF[CNT_W-1:0];
    end else begin : g_sysBase
      assign defDiv = SYS_DEF[CNT_W-1:0];
    end
  endgenerate

  assign rateDivW = rateDiv[CNT_W-1:0];

  txrate_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .linkRun (linkRun),
    .rateDiv (rateDivW),
    .defDiv  (defDiv),
    .cnt     (cntQ),
    .selDiv  (selDiv),
    .ctl     (ctl)
  );

  txrate_dp #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .selDiv (selDiv),
    .cnt    (cntQ),
    .bitEn  (bitEn)
  );

endmodule

// File: rtl/txrate_scaler_chk.sv
module txrate_scaler_chk #(
  parameter int CNT_W        = 8,
  parameter int SYS_FREQ_HZ  = 200_000_000,
  parameter int TX_FREQ_HZ   = 50_000_000,
  parameter int BIT_RATE_HZ  = 10_000_000,
  parameter bit USE_FAST_CLK = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic             linkRun,
  input logic [7:0]       rateDiv,
  input logic             bitEn,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] selDiv
);

  localparam int BASE_HZ = USE_FAST_CLK ? TX_FREQ_HZ : SYS_FREQ_HZ;
  localparam int EXP_DEF_I = BASE_HZ / BIT_RATE_HZ - 1;
  localparam logic [CNT_W-1:0] EXP_DEF = EXP_DEF_I[CNT_W-1:0];

  // R1: reset clears the counter and the strobe
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (cnt == '0 && !bitEn));

  // R2 and R3: reload with the link idle takes the default divisor
  assert_idle_default_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!linkRun && cnt == '0) |=> cnt == EXP_DEF);

  // R4: reload with the link running takes the runtime divisor
  assert_run_divisor_R4: assert property (@(posedge clk) disable iff (!rstN)
    (linkRun && cnt == '0) |=> cnt == $past(rateDiv[CNT_W-1:0]));

  // R6: a zero count produces a strobe on the next cycle
  assert_pulse_on_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0) |=> bitEn);

  // R6: no strobe while the count is running down
  assert_no_midcount_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0 && cnt <= selDiv) |=> !bitEn);

  // R7: a count above the divisor reloads at once with a strobe
  assert_shrink_reload_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cnt > selDiv) |=> (bitEn && cnt == $past(selDiv)));

  // R9: countdown by one between reloads
  assert_countdown_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0 && cnt <= selDiv) |=> cnt == $past(cnt) - 1'b1);

endmodule

bind txrate_scaler txrate_scaler_chk #(
  .CNT_W        (CNT_W),
  .SYS_FREQ_HZ  (SYS_FREQ_HZ),
  .TX_FREQ_HZ   (TX_FREQ_HZ),
  .BIT_RATE_HZ  (BIT_RATE_HZ),
  .USE_FAST_CLK (USE_FAST_CLK)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .linkRun (linkRun),
  .rateDiv (rateDiv),
  .bitEn   (bitEn),
  .cnt     (cntQ),
  .selDiv  (selDiv)
);

// File: tb/sim_txrate_scaler.sv
`timescale 1ns/1ps
module sim_txrate_scaler;

  typedef struct packed {
    logic       run;
    logic [7:0] div;
    logic [8:0] gap;
  } vec_t;

  // generic build: default divisor 19 -> spacing 20
  localparam vec_t VEC [0:7] = '{
    {1'b0, 8'd55,  9'd20},   // R3 rateDiv ignored while idle
    {1'b1, 8'd0,   9'd1},    // R5 divisor 0
    {1'b1, 8'd1,   9'd2},    // R4
    {1'b1, 8'd7,   9'd8},    // R4
    {1'b1, 8'd255, 9'd256},  // R5 divisor 255
    {1'b0, 8'd0,   9'd20},   // R3
    {1'b1, 8'd19,  9'd20},   // R4
    {1'b1, 8'd100, 9'd101}   // R4
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic linkRun = 1'b0;
  logic [7:0] rateDiv = 8'd0;
  logic bitEn0;
  logic bitEn1;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  txrate_scaler #(.USE_FAST_CLK(1'b0), .SYS_FREQ_HZ(200_000_000)) u0 (
    .clk(clk), .rstN(rstN), .linkRun(linkRun), .rateDiv(rateDiv), .bitEn(bitEn0));

  txrate_scaler #(.USE_FAST_CLK(1'b1), .SYS_FREQ_HZ(200_000_000),
                  .TX_FREQ_HZ(50_000_000)) u1 (
    .clk(clk), .rstN(rstN), .linkRun(linkRun), .rateDiv(rateDiv), .bitEn(bitEn1));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input bit sel);
    return sel ? bitEn1 : bitEn0;
  endfunction

  task automatic gapOf(input bit sel, output int g);
    int n;
    do @(negedge clk); while (!pick(sel));
    n = 0;
    do begin @(negedge clk); n++; end while (!pick(sel));
    g = n;
  endtask

  task automatic waitPulse(input bit sel);
    do @(negedge clk); while (!pick(sel));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int g;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(bitEn0 == 1'b0, "R1 strobe low in reset", bitEn0, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(bitEn0 == 1'b1, "R1 first strobe after release", bitEn0, 1);
    @(negedge clk);
    check(bitEn0 == 1'b0, "R6 strobe one cycle wide", bitEn0, 0);
    gapOf(1'b0, g);
    check(g == 20, "R2 R3 generic default spacing", g, 20);
    gapOf(1'b1, g);
    check(g == 5, "R2 R3 fast-mode default spacing", g, 5);

    // table walk (R3 R4 R5 R6 R9)
    for (int i = 0; i < 8; i++) begin
      linkRun = VEC[i].run;
      rateDiv = VEC[i].div;
      gapOf(1'b0, g);
      gapOf(1'b0, g);
      check(g == int'(VEC[i].gap), $sformatf("R4 R9 vector %0d spacing", i), g, int'(VEC[i].gap));
    end

    // R7 shrinking divisor mid-count
    linkRun = 1'b1; rateDiv = 8'd200;
    gapOf(1'b0, g);
    waitPulse(1'b0);
    rateDiv = 8'd3;
    @(negedge clk);
    check(bitEn0 == 1'b1, "R7 immediate reload on shrink", bitEn0, 1);
    gapOf(1'b0, g);
    check(g == 4, "R7 spacing after shrink", g, 4);

    // R8 idle to running switch (count 19 above new divisor 2)
    linkRun = 1'b0;
    gapOf(1'b0, g);
    waitPulse(1'b0);
    linkRun = 1'b1; rateDiv = 8'd2;
    @(negedge clk);
    check(bitEn0 == 1'b1, "R8 switch to runtime divisor immediate", bitEn0, 1);
    gapOf(1'b0, g);
    check(g == 3, "R8 runtime spacing after switch", g, 3);

    // R8 running to idle switch (count 255 above default 19)
    rateDiv = 8'd255;
    gapOf(1'b0, g);
    waitPulse(1'b0);
    linkRun = 1'b0;
    @(negedge clk);
    check(bitEn0 == 1'b1, "R8 link drop reload immediate", bitEn0, 1);
    gapOf(1'b0, g);
    check(g == 20, "R8 default spacing after drop", g, 20);

    // R4 fast build with runtime divisor
    linkRun = 1'b1; rateDiv = 8'd9;
    gapOf(1'b1, g);
    gapOf(1'b1, g);
    check(g == 10, "R4 fast-mode runtime spacing", g, 10);

    // R1 reset mid-run
    rateDiv = 8'd50;
    gapOf(1'b0, g);
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(bitEn0 == 1'b0, "R1 strobe cleared by mid-run reset", bitEn0, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(bitEn0 == 1'b1, "R1 strobe right after re-release", bitEn0, 1);
    gapOf(1'b0, g);
    check(g == 51, "R4 spacing after re-release", g, 51);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule